// File: doc/BRIEF.md
# Serial Control Register Port

This block is a slave port on a four-wire serial link (select, clock, data in, data out). It gives an external controller access to a small bank of 8-bit control registers that the rest of the chip reads in parallel. Every transaction opens with a command byte. The command byte carries a direction flag and a 5-bit start address. All bytes after it move data to or from successive register addresses, because the address advances by one after each byte. A burst may be of any length.

The serial pins are asynchronous to the system clock. They pass through a synchronizer, and the port finds clock edges by comparing successive synchronized samples. The system clock must therefore be several times faster than the serial clock.

The register space has three regions:
- Addresses 0x00 to 0x08 are writable registers.
- Addresses 0x09 and 0x0A hold a fixed 16-bit identification value.
- All higher addresses read as zero and take no writes.

Top module: `serRegPort`

## Requirements
- R1: After reset the parallel register outputs show 0x3F at address 0x00 and 0x03 at address 0x01. Addresses 0x02 to 0x08 show 0x00. Register n sits at bits [8n+7:8n] of `regsOut`.
- R2: Bits are sampled on the rising serial clock edge, least significant bit first. The first byte after select goes low is the command: bit 7 is 1 for a write, and bits 4:0 are the start address. In a write, each later byte is stored at the current address.
- R3: In a read, the byte at the start address and then the bytes at the following addresses are shifted out on `sdo`, least significant bit first. Each bit changes after a falling serial clock edge and is valid at the following rising edge.
- R4: During a read, the data on `sdi` is ignored and no register changes.
- R5: Address 0x09 reads `ID_CODE[7:0]` and address 0x0A reads `ID_CODE[15:8]`. Writes to these two addresses have no effect.
- R6: Addresses 0x0B to 0x1F read as 0x00. Writes to them change no register.
- R7: Raising select discards any partial byte. The next byte after select falls again is taken as a new command.
- R8: `sdo` is 0 while select is high.
- R9: The address advances by one after each completed data byte and wraps from 0x1F to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idle high |
| sdi | input | 1 | Serial data into the port |
| sdo | output | 1 | Serial data out of the port |
| regsOut | output | NUM_RW*8 | Parallel contents of the writable registers |

## Verification
The assertions assume that each serial clock half period lasts at least three system clocks. This lets one byte's strobe settle before the next edge arrives. They also assume that `sdi` is stable across each rising edge and that select changes only while the serial clock is high.

The bench holds each half period at eight system clocks. It changes `sdi` and select only alongside a falling edge or during the idle-high phase. Random bursts cover both directions, every start address and lengths of up to six bytes.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              cmdStb;    // command byte completed
    logic              byteStb;   // data byte completed
    logic              shiftStb;  // present next read bit
    logic              idle;      // select inactive
    logic              isWrite;   // direction of current burst
    logic [BYTE_W-1:0] rxByte;    // byte just received
  } portStrobeT;
endpackage

// File: rtl/serCtrl.sv
module serCtrl
  import ser_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  output portStrobeT strb
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] csSy, ckSy, dSy;
  logic csS, ckS, dS, ckPrev;
  logic rise, fall;
  logic [CNT_W-1:0] bitCnt;
  logic cmdPhase, isWrite;
  logic [BYTE_W-2:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSy   <= '1;
      ckSy   <= '1;
      dSy    <= '0;
      ckPrev <= 1'b1;
    end else begin
      csSy   <= {csSy[SYNC_STAGES-2:0], csN};
      ckSy   <= {ckSy[SYNC_STAGES-2:0], sclk};
      dSy    <= {dSy[SYNC_STAGES-2:0], sdi};
      ckPrev <= ckS;
    end
  end

  assign csS  = csSy[SYNC_STAGES-1];
  assign ckS  = ckSy[SYNC_STAGES-1];
  assign dS   = dSy[SYNC_STAGES-1];
  assign rise = !csS && ckS && !ckPrev;
  assign fall = !csS && !ckS && ckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      cmdPhase <= 1'b1;
      isWrite  <= 1'b0;
      rxShift  <= '0;
    end else if (csS) begin
      bitCnt   <= '0;
      cmdPhase <= 1'b1;
      isWrite  <= 1'b0;
    end else if (rise) begin
      rxShift <= {dS, rxShift[BYTE_W-2:1]};
      bitCnt  <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT && cmdPhase) begin
        cmdPhase <= 1'b0;
        isWrite  <= dS;
      end
    end
  end

  always_comb begin
    strb.cmdStb   = rise && bitCnt == LAST_BIT && cmdPhase;
    strb.byteStb  = rise && bitCnt == LAST_BIT && !cmdPhase;
    strb.shiftStb = fall && !cmdPhase && !isWrite;
    strb.idle     = csS;
    strb.isWrite  = isWrite;
    strb.rxByte   = {dS, rxShift};
  end

  AST_ABORT_TO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (cmdPhase && bitCnt == '0)); // R7
  AST_CMD_THEN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdStb |=> (!cmdPhase && bitCnt == '0)); // R2
endmodule

// File: rtl/regDatapath.sv
module regDatapath
  import ser_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NUM_RW = 9,
  parameter logic [NUM_RW*BYTE_W-1:0] RST_VALS = '0,
  parameter logic [2*BYTE_W-1:0] ID_CODE = 16'hA55C
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  portStrobeT               strb,
  output logic                     sdo,
  output logic [NUM_RW*BYTE_W-1:0] regsOut
);
  localparam int ID_LO = NUM_RW;
  localparam int ID_HI = NUM_RW + 1;

  logic [NUM_RW*BYTE_W-1:0] regBank;
  logic [ADDR_W-1:0] curAddr, nextAddr, cmdAddr;
  logic [BYTE_W-1:0] txShift;
  logic sdoQ;

  function automatic logic [BYTE_W-1:0] rdSel(input logic [ADDR_W-1:0] a);
    logic [BYTE_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (a == ADDR_W'(i)) v = regBank[i*BYTE_W +: BYTE_W];
    if (a == ADDR_W'(ID_LO)) v = ID_CODE[BYTE_W-1:0];
    if (a == ADDR_W'(ID_HI)) v = ID_CODE[2*BYTE_W-1:BYTE_W];
    return v;
  endfunction

  assign nextAddr = curAddr + 1'b1;
  assign cmdAddr  = strb.rxByte[ADDR_W-1:0];

  generate
    for (genvar g = 0; g < NUM_RW; g++) begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regBank[g*BYTE_W +: BYTE_W] <= RST_VALS[g*BYTE_W +: BYTE_W];
        else if (strb.byteStb && strb.isWrite && curAddr == ADDR_W'(g))
          regBank[g*BYTE_W +: BYTE_W] <= strb.rxByte;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      txShift <= '0;
      sdoQ    <= 1'b0;
    end else begin
      if (strb.cmdStb) begin
        curAddr <= cmdAddr;
        txShift <= rdSel(cmdAddr);
      end else if (strb.byteStb) begin
        curAddr <= nextAddr;
        txShift <= rdSel(nextAddr);
      end else if (strb.shiftStb) begin
        txShift <= {1'b0, txShift[BYTE_W-1:1]};
      end
      if (strb.idle)
        sdoQ <= 1'b0;
      else if (strb.shiftStb)
        sdoQ <= txShift[0];
    end
  end

  assign sdo     = sdoQ;
  assign regsOut = regBank;

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteStb && !strb.isWrite) |=> $stable(regsOut)); // R4
  AST_HIGH_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.byteStb && curAddr >= ADDR_W'(NUM_RW)) |=> $stable(regsOut)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteStb |=> curAddr == ($past(curAddr) + ADDR_W'(1))); // R9
  AST_IDLE_SDO: assert property (@(posedge clk) disable iff (!rstN)
    strb.idle |=> !sdo); // R8
endmodule

// File: rtl/serRegPort.sv
module serRegPort
  import ser_reg_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int NUM_RW      = 9,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_RW*BYTE_W-1:0] RST_VALS = 72'h00_00_00_00_00_00_00_03_3F,
  parameter logic [2*BYTE_W-1:0] ID_CODE = 16'hA55C
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     sclk,
  input  logic                     sdi,
  output logic                     sdo,
  output logic [NUM_RW*BYTE_W-1:0] regsOut
);
  portStrobeT strb;

  serCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .strb(strb)
  );

  regDatapath #(
    .ADDR_W(ADDR_W), .NUM_RW(NUM_RW), .RST_VALS(RST_VALS), .ID_CODE(ID_CODE)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .sdo(sdo), .regsOut(regsOut)
  );
endmodule

// File: tb/serRegPort_test.sv
module serRegPort_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NUM_RW = 9;
  localparam logic [15:0] IDC = 16'hA55C;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic sdo;
  logic [NUM_RW*8-1:0] regsOut;

  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [7:0] mdl [NUM_RW];
  logic [7:0] wBuf [8];
  logic [7:0] rBuf [8];

  serRegPort uut (.clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
                  .sdo(sdo), .regsOut(regsOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] expRead(input logic [4:0] a);
    if (a < NUM_RW) return mdl[a];
    if (a == 5'd9) return IDC[7:0];
    if (a == 5'd10) return IDC[15:8];
    return 8'h00;
  endfunction

  function automatic logic [NUM_RW*8-1:0] expRegs();
    logic [NUM_RW*8-1:0] v;
    for (int i = 0; i < NUM_RW; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      sdi  = b[i];
      waitClk(HALF);
      got[i] = sdo;
      sclk = 1'b1;
      waitClk(HALF);
    end
  endtask

  // one transaction: command then n data bytes from wBuf, replies into rBuf
  task automatic xfer(input bit wr, input logic [4:0] addr, input int n);
    logic [7:0] g;
    csN = 1'b0;
    waitClk(HALF);
    sendByte({wr, 2'b00, addr}, g);
    for (int k = 0; k < n; k++) begin
      sendByte(wBuf[k], g);
      rBuf[k] = g;
      if (wr && ((addr + k) % 32) < NUM_RW) mdl[(addr + k) % 32] = wBuf[k];
    end
    waitClk(HALF);
    csN = 1'b1;
    waitClk(2*HALF);
  endtask

  task automatic checkReads(input string req, input logic [4:0] addr, input int n);
    for (int k = 0; k < n; k++)
      check(req, 128'(rBuf[k]), 128'(expRead(5'((addr + k) % 32))));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    void'($urandom(32'd7));
    mdl[0] = 8'h3F; mdl[1] = 8'h03;
    for (int i = 2; i < NUM_RW; i++) mdl[i] = 8'h00;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    // R1 reset values, R8 idle output
    check("R1", 128'(regsOut), 128'(expRegs()));
    check("R8", 128'(sdo), 128'(0));

    // R3 read reset values from 0x00
    xfer(1'b0, 5'd0, 3);
    checkReads("R3", 5'd0, 3);
    check("R8", 128'(sdo), 128'(0));

    // R2 write burst then read back
    wBuf[0] = 8'hA1; wBuf[1] = 8'h5E; wBuf[2] = 8'h80;
    xfer(1'b1, 5'd2, 3);
    check("R2", 128'(regsOut), 128'(expRegs()));
    xfer(1'b0, 5'd2, 3);
    checkReads("R2", 5'd2, 3);

    // R5 ID read, write attempt ignored
    xfer(1'b0, 5'd9, 2);
    checkReads("R5", 5'd9, 2);
    wBuf[0] = 8'h11; wBuf[1] = 8'h22;
    xfer(1'b1, 5'd9, 2);
    check("R5", 128'(regsOut), 128'(expRegs()));
    xfer(1'b0, 5'd9, 2);
    checkReads("R5", 5'd9, 2);

    // R6 high addresses
    wBuf[0] = 8'hFF; wBuf[1] = 8'hEE;
    xfer(1'b1, 5'd11, 2);
    check("R6", 128'(regsOut), 128'(expRegs()));
    xfer(1'b0, 5'd11, 3);
    checkReads("R6", 5'd11, 3);

    // R9 wrap from 0x1F to 0x00
    wBuf[0] = 8'h77; wBuf[1] = 8'hC4;
    xfer(1'b1, 5'd31, 2);
    check("R9", 128'(regsOut[7:0]), 128'(8'hC4));
    xfer(1'b0, 5'd31, 3);
    checkReads("R9", 5'd31, 3);

    // R4 read with noisy sdi leaves registers alone
    wBuf[0] = 8'hFF; wBuf[1] = 8'h00; wBuf[2] = 8'hAA;
    xfer(1'b0, 5'd0, 3);
    checkReads("R4", 5'd0, 3);
    check("R4", 128'(regsOut), 128'(expRegs()));

    // R7 partial byte then abort, next byte is a command
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0; sdi = 1'b1; waitClk(HALF);
      sclk = 1'b1; waitClk(HALF);
    end
    csN = 1'b1;
    waitClk(2*HALF);
    check("R8", 128'(sdo), 128'(0));
    wBuf[0] = 8'h5A;
    xfer(1'b1, 5'd4, 1);
    check("R7", 128'(regsOut), 128'(expRegs()));

    // random bursts
    for (int t = 0; t < 40; t++) begin
      bit wr = 1'($urandom % 2);
      logic [4:0] a = 5'($urandom % 32);
      int n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) wBuf[k] = 8'($urandom);
      xfer(wr, a, n);
      if (wr) check("R2", 128'(regsOut), 128'(expRegs()));
      else begin
        checkReads("R3", a, n);
        check("R4", 128'(regsOut), 128'(expRegs()));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule